// File: doc/BRIEF.md
# Integer Add/Subtract/Compare Unit

This block is the integer arithmetic slice of a processor execute stage. It is purely combinational. It takes two 32-bit register operands and an optional 16-bit immediate, and an operation code picks one of six operations: add, subtract and set-less-than, each in a signed and an unsigned form. It returns a 32-bit result and a flag that asks the pipeline to take an overflow exception.

When the immediate select is high, the immediate replaces the second operand. It is always widened by copying its top bit into the upper bits, and this holds for the unsigned add as well. Subtraction adds the inverted second operand with a carry-in of one. The signed add and subtract are the only operations that can raise the exception flag. Their unsigned forms wrap silently. The two comparisons return 0 or 1 in bit 0.

The block has no state, so the naming follows the style: `op_decode` maps each operation code to a set of named control lines, `add_core` holds the single shared adder, and `imm_widen` does the immediate extension.

Top module: `int_arith_unit`

## Requirements
- R1: The operation code `op_i` uses this encoding: 0 signed add, 1 unsigned add, 2 signed subtract, 3 unsigned subtract, 4 signed set-less-than, 5 unsigned set-less-than. Codes 6 and 7 give a result of 0 with the flag low.
- R2: Add (codes 0 and 1) drives `res_o` with the sum of the two operands, modulo 2^32.
- R3: Subtract (codes 2 and 3) drives `res_o` with the first operand minus the second, modulo 2^32. This equals the first operand plus the inverted second operand plus one.
- R4: With `use_imm_i` high, the second operand is `imm_i` with bit 15 copied into bits 31..16. This applies to every code, including the unsigned add.
- R5: For code 0, `ovf_o` is 1 exactly when both operands have the same bit 31 and the bit 31 of the result differs from it. Operands of opposite sign never set the flag.
- R6: For code 2, `ovf_o` is 1 exactly when the bits 31 of the operands differ and the bit 31 of the result differs from that of the first operand.
- R7: For codes 1, 3, 4, 5, 6 and 7, `ovf_o` is 0. The result is still driven normally when the flag is raised.
- R8: Code 4 returns 1 in bit 0 when the first operand is less than the second as a signed number, where bit 31 is the sign and zero counts as non-negative. All other bits are 0.
- R9: Code 5 returns 1 in bit 0 when the first operand is less than the second as an unsigned number. All other bits are 0. For example, 0xFFFFFFFF compared with 0x00000001 gives 1 under code 4 and 0 under code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (encoding in R1) |
| use_imm_i | input | 1 | 1: the second operand is the widened immediate |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate, sign-extended when used |
| res_o | output | 32 | Result |
| ovf_o | output | 1 | Request for a signed overflow exception |

## Verification
The bench goes after the following corner cases, and for each one names the failure it would expose:
- The largest positive value plus one, and the most negative value plus minus one. A design with a reversed or missing overflow term would stay silent here.
- Zero minus the most negative value. A design that tests overflow against the uninverted second operand would stay silent here.
- Overflowing unsigned adds and subtracts. A design that lets the flag through for every arithmetic code would raise it here.
- An unsigned-immediate add with immediate 0xFFFF. A design that zero-extends would give the wrong sum.
- Mixed-sign comparisons, such as all ones against one. A design that swaps the signed and unsigned rules, or drops the overflow correction from the signed compare, would return the wrong bit.

A behavioural model built on 64-bit integers also checks a long pseudo-random stream, with every operation code and both operand sources.

// File: rtl/int_arith_pkg.sv
package int_arith_pkg;

    typedef enum logic [2:0] {
        ARITH_ADD  = 3'd0,
        ARITH_ADDU = 3'd1,
        ARITH_SUB  = 3'd2,
        ARITH_SUBU = 3'd3,
        ARITH_SLT  = 3'd4,
        ARITH_SLTU = 3'd5,
        ARITH_RSV6 = 3'd6,
        ARITH_RSV7 = 3'd7
    } arith_op_e;

    typedef struct packed {
        logic invert_b;   // subtract: invert operand b, carry in one
        logic trap_en;    // signed overflow may raise the exception
        logic pick_sum;
        logic pick_slt;
        logic pick_sltu;
    } arith_ctl_t;

endpackage

// File: rtl/imm_widen.sv
module imm_widen #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm_i,
    output logic [WIDTH-1:0] wide_o
);
    localparam int FILL_W = WIDTH - IMM_W;

    generate
        if (FILL_W > 0) begin : g_fill
            assign wide_o = {{FILL_W{imm_i[IMM_W-1]}}, imm_i};
        end else begin : g_trunc
            assign wide_o = imm_i[WIDTH-1:0];
        end
    endgenerate
endmodule

// File: rtl/op_decode.sv
module op_decode
    import int_arith_pkg::*;
(
    input  arith_op_e  op_i,
    output arith_ctl_t ctl_o
);
    always_comb begin
        ctl_o = '0;
        unique case (op_i)
            ARITH_ADD:  begin ctl_o.trap_en = 1'b1; ctl_o.pick_sum = 1'b1; end
            ARITH_ADDU: begin ctl_o.pick_sum = 1'b1; end
            ARITH_SUB:  begin ctl_o.invert_b = 1'b1; ctl_o.trap_en = 1'b1; ctl_o.pick_sum = 1'b1; end
            ARITH_SUBU: begin ctl_o.invert_b = 1'b1; ctl_o.pick_sum = 1'b1; end
            ARITH_SLT:  begin ctl_o.invert_b = 1'b1; ctl_o.pick_slt = 1'b1; end
            ARITH_SLTU: begin ctl_o.invert_b = 1'b1; ctl_o.pick_sltu = 1'b1; end
            ARITH_RSV6: ctl_o = '0;
            ARITH_RSV7: ctl_o = '0;
        endcase
    end
endmodule

// File: rtl/add_core.sv
module add_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             invert_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             sovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    assign b_eff  = invert_i ? ~b_i : b_i;
    assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, invert_i};
    assign sum_o  = full[MSB:0];
    assign cout_o = full[WIDTH];
    // same-sign inputs to the adder whose sum flips sign
    assign sovf_o = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
endmodule

// File: rtl/int_arith_unit.sv
module int_arith_unit
    import int_arith_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [2:0]       op_i,
    input  logic             use_imm_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [WIDTH-1:0] res_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    arith_ctl_t       ctl;
    logic [WIDTH-1:0] imm_wide;
    logic [WIDTH-1:0] b_sel;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             sovf;
    logic             lt_s;
    logic             lt_u;

    op_decode u_dec (
        .op_i  (arith_op_e'(op_i)),
        .ctl_o (ctl)
    );

    imm_widen #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_imm (
        .imm_i  (imm_i),
        .wide_o (imm_wide)
    );

    assign b_sel = use_imm_i ? imm_wide : opb_i;

    add_core #(.WIDTH(WIDTH)) u_add (
        .a_i      (opa_i),
        .b_i      (b_sel),
        .invert_i (ctl.invert_b),
        .sum_o    (sum),
        .cout_o   (cout),
        .sovf_o   (sovf)
    );

    assign lt_s = sum[MSB] ^ sovf;
    assign lt_u = ~cout;

    always_comb begin
        res_o = '0;
        if (ctl.pick_sum)
            res_o = sum;
        else if (ctl.pick_slt)
            res_o = {{MSB{1'b0}}, lt_s};
        else if (ctl.pick_sltu)
            res_o = {{MSB{1'b0}}, lt_u};
        ovf_o = ctl.trap_en & sovf;
    end
endmodule

// File: rtl/int_arith_chk.sv
module int_arith_chk #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input logic [2:0]       op_i,
    input logic             use_imm_i,
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [IMM_W-1:0] imm_i,
    input logic [WIDTH-1:0] res_o,
    input logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_seen;
    assign b_seen = use_imm_i ? WIDTH'($signed(imm_i)) : opb_i;

    always_comb begin
        // R7
        no_overflow_chk: assert (!(ovf_o && !(op_i == 3'd0 || op_i == 3'd2)));
        // R5
        mixed_sign_add_chk: assert (!(op_i == 3'd0 && opa_i[MSB] != b_seen[MSB] && ovf_o));
        // R6
        same_sign_sub_chk: assert (!(op_i == 3'd2 && opa_i[MSB] == b_seen[MSB] && ovf_o));
        // R8
        slt_upper_chk: assert (!((op_i == 3'd4 || op_i == 3'd5) && res_o[MSB:1] != '0));
        // R1
        reserved_zero_chk: assert (!(op_i[2:1] == 2'b11 && res_o != '0));
        // R2
        add_sum_chk: assert (!(op_i[2:1] == 2'b00 && res_o != opa_i + b_seen));
    end
endmodule

bind int_arith_unit int_arith_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
    .op_i      (op_i),
    .use_imm_i (use_imm_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .imm_i     (imm_i),
    .res_o     (res_o),
    .ovf_o     (ovf_o)
);

// File: tb/int_arith_unit_tb.sv
module int_arith_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op = 3'd0;
    logic        use_imm = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [15:0] imm = '0;
    logic [31:0] res;
    logic        ovf;

    int checks = 0;
    int fails  = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #5 clk = ~clk;

    int_arith_unit u_dut (
        .op_i      (op),
        .use_imm_i (use_imm),
        .opa_i     (a),
        .opb_i     (b),
        .imm_i     (imm),
        .res_o     (res),
        .ovf_o     (ovf)
    );

    // behavioural reference on 64-bit integers
    task automatic model(output logic [31:0] er, output logic eo);
        longint sa, sb, sr;
        longint ua, ub;
        logic [31:0] bv;
        bv = use_imm ? {{16{imm[15]}}, imm} : b;
        sa = longint'($signed(a));
        sb = longint'($signed(bv));
        ua = longint'({32'd0, a});
        ub = longint'({32'd0, bv});
        er = '0;
        eo = 1'b0;
        case (op)
            3'd0, 3'd1: begin
                sr = sa + sb;
                er = sr[31:0];
                if (op == 3'd0) eo = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            3'd2, 3'd3: begin
                sr = sa - sb;
                er = sr[31:0];
                if (op == 3'd2) eo = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            3'd4: er = (sa < sb) ? 32'd1 : 32'd0;
            3'd5: er = (ua < ub) ? 32'd1 : 32'd0;
            default: er = '0;
        endcase
    endtask

    task automatic apply(input string tag, input logic [2:0] o, input logic ui,
                         input logic [31:0] va, input logic [31:0] vb, input logic [15:0] vi);
        logic [31:0] er;
        logic eo;
        @(posedge clk);
        op = o; use_imm = ui; a = va; b = vb; imm = vi;
        @(negedge clk);
        model(er, eo);
        checks++;
        if (res !== er || ovf !== eo) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h: res=%h ovf=%b expected res=%h ovf=%b",
                     tag, o, va, vb, vi, res, ovf, er, eo);
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs give zero, no flag (R1 R2)
        apply("R2 reset", 3'd0, 1'b0, 32'd0, 32'd0, 16'd0);
        // R5 overflow corners
        apply("R5 maxpos+1", 3'd0, 1'b0, 32'h7FFF_FFFF, 32'd1, 16'd0);
        apply("R5 minneg+-1", 3'd0, 1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 16'd0);
        apply("R5 mixed sign", 3'd0, 1'b0, 32'h7FFF_FFFF, 32'h8000_0000, 16'd0);
        // R6
        apply("R6 0-minneg", 3'd2, 1'b0, 32'd0, 32'h8000_0000, 16'd0);
        apply("R6 minneg-1", 3'd2, 1'b0, 32'h8000_0000, 32'd1, 16'd0);
        apply("R6 same sign", 3'd2, 1'b0, 32'hFFFF_FFFF, 32'h8000_0000, 16'd0);
        // R7 unsigned never flags, result still driven
        apply("R7 addu wrap", 3'd1, 1'b0, 32'h7FFF_FFFF, 32'd1, 16'd0);
        apply("R7 subu wrap", 3'd3, 1'b0, 32'd0, 32'h8000_0000, 16'd0);
        // R3
        apply("R3 sub basic", 3'd3, 1'b0, 32'd7, 32'd6, 16'd0);
        // R4 immediate sign extension, also on unsigned add
        apply("R4 addiu neg", 3'd1, 1'b1, 32'd5, 32'hDEAD_BEEF, 16'hFFFF);
        apply("R4 addi pos", 3'd0, 1'b1, 32'h7FFF_8000, 32'd0, 16'h7FFF);
        apply("R4 slti", 3'd4, 1'b1, 32'hFFFF_FFF0, 32'd0, 16'hFFF8);
        // R8 R9
        apply("R8 slt -1<1", 3'd4, 1'b0, 32'hFFFF_FFFF, 32'd1, 16'd0);
        apply("R9 sltu -1<1", 3'd5, 1'b0, 32'hFFFF_FFFF, 32'd1, 16'd0);
        apply("R8 slt ovf corr", 3'd4, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'd0);
        apply("R9 sltu equal", 3'd5, 1'b0, 32'h1234_5678, 32'h1234_5678, 16'd0);
        // R1 reserved codes
        apply("R1 rsv6", 3'd6, 1'b0, 32'h7FFF_FFFF, 32'd1, 16'd0);
        apply("R1 rsv7", 3'd7, 1'b1, 32'hFFFF_FFFF, 32'd1, 16'hFFFF);
        // random stream over every code and operand source (R1..R9)
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] ra, rb;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rb = lfsr * 32'd2654435761;
            if (i[2]) ra[31:30] = rb[1:0];
            apply("R2 random", 3'(i % 8), rb[7], ra, rb, ra[15:0] ^ rb[31:16]);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule